// File: doc/BRIEF.md
# Two-Way Latched/Registered Bus Transceiver

This block sits between two data buses, called side A and side B, and moves words in both directions. Each direction has its own storage element and its own four controls: an active-low output enable, a latch enable, a data strobe that acts as that direction's clock, and an active-low strobe enable. The storage element of a direction has three modes. It can pass the source word straight through (transparent), hold the word it has (latched), or take a new word on a rising strobe edge (registered). The latch-enable level picks between the pass-through mode and the edge-triggered mode.

Pads are modelled as separate input word, output word and drive-enable signals for each side. The pad ring or the bus fabric resolves the three-state behaviour. The strobes are sampled on the block clock, so a strobe edge is a low sample followed by a high sample. A synchronous active-low reset stands in for power-up. It empties both stores and takes both sides off the bus. When both sides are enabled to drive at the same time, a clash flag is raised and each side still follows its own enable.

Top module: `duplex_latch_xcvr`

## Requirements
- R1: While `rst_n` is low, both drive enables are 0 whatever the output enables are. A reset clock edge clears both stores to zero. A strobe that is already high when reset is released is not treated as an edge.
- R2: While a direction's latch enable is 1, its output word equals its source word in the same cycle, with no clock edge in between.
- R3: When the latch enable goes from 1 to 0, the output holds the source word that was present at the last clock edge at which the latch enable was 1.
- R4: With the latch enable at 0 and the strobe enable at 0, a strobe sampled 0 and then 1 on consecutive clock edges loads the source word from that edge. The new word appears on the output from the following cycle.
- R5: With the strobe enable at 1, strobe edges load nothing and the output word stays unchanged while the latch enable is 0.
- R6: With the latch enable at 0 and the strobe held at a steady level (high or low), the output word does not change. This includes the case where the latch enable falls while the strobe is already high.
- R7: Outside reset, a direction's drive enable is 1 exactly when its output enable is 0. The output enable has no effect on the stored word or on the output word.
- R8: The two directions follow R2 to R7 independently. Controls of one direction never change the word stored in the other.
- R9: The clash flag is 1 exactly when both drive enables are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; strobes are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset (power-up stand-in) |
| a_in | input | W | Word received from the side-A pads |
| a_out | output | W | Word presented to the side-A pads (B-to-A path) |
| a_drive | output | 1 | Side-A pad drive enable |
| b_in | input | W | Word received from the side-B pads |
| b_out | output | W | Word presented to the side-B pads (A-to-B path) |
| b_drive | output | 1 | Side-B pad drive enable |
| ab_oe_n | input | 1 | A-to-B output enable, active low |
| ab_le | input | 1 | A-to-B latch enable, 1 = transparent |
| ab_strobe | input | 1 | A-to-B data strobe, rising edge loads |
| ab_ce_n | input | 1 | A-to-B strobe enable, active low |
| ba_oe_n | input | 1 | B-to-A output enable, active low |
| ba_le | input | 1 | B-to-A latch enable, 1 = transparent |
| ba_strobe | input | 1 | B-to-A data strobe, rising edge loads |
| ba_ce_n | input | 1 | B-to-A strobe enable, active low |
| bus_clash | output | 1 | Both sides driving at once |

## Verification
The bench targets the moment the latch enable falls while the source word is changing. A design that stopped capturing early would show the new word or a stale word instead of the last transparent one. It also drops the latch enable while the strobe is already high. A design that took any high strobe as an edge would load a word there. Strobe edges are sent with the strobe enable high, where a faulty enable gate would change the output. Reset is released with the strobe high and the output enables low, to catch a phantom load and a drive before reset ends. A long sweep of mixed control patterns in both directions, compared against a cycle model, checks that one direction's controls never disturb the other.

// File: rtl/dlx_pkg.sv
// Shared types for the two-way latched/registered transceiver.
package dlx_pkg;
    // Control bundle for one direction; field order matters for packing at the top.
    typedef struct packed {
        logic oe_n;    // output enable, active low
        logic le;      // latch enable, 1 = transparent
        logic strobe;  // data strobe, rising edge loads
        logic ce_n;    // strobe enable, active low
    } dlx_ctrl_t;

    localparam int unsigned DLX_NDIR = 2;
endpackage

// File: rtl/dlx_strobe_edge.sv
// Rising-edge detector for a direction's data strobe.
// Assumes the strobe is synchronous to clk. The sampled history resets to 1,
// so a strobe already high when reset is released does not count as an edge.
module dlx_strobe_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    output logic rise
);
    logic strobe_q;

    // Keep the strobe level seen at the previous clock edge.
    always_ff @(posedge clk) begin
        if (!rst_n) strobe_q <= 1'b1;
        else        strobe_q <= strobe;
    end

    // An edge is a low sample followed by a high sample.
    always_comb rise = strobe & ~strobe_q;
endmodule

// File: rtl/dlx_store_cell.sv
// Merged latch/register storage for one direction.
// While le is 1 the cell passes din straight through and records it on every edge,
// so the word shown last is the word held once le falls. While le is 0 the cell
// loads only when load_en is 1. Assumes load_en is a single-cycle qualified edge.
module dlx_store_cell #(
    parameter int unsigned W = 18
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         le,
    input  logic         load_en,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] held;

    // Update the held word in transparent mode or on a qualified strobe edge.
    always_ff @(posedge clk) begin
        if (!rst_n)       held <= '0;
        else if (le)      held <= din;
        else if (load_en) held <= din;
    end

    // Pass-through in transparent mode, stored word otherwise.
    always_comb dout = le ? din : held;

    // R3: after le falls, the word present at the last transparent edge is held.
    p_capture_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(le) && !le) |-> (dout == $past(din)));
endmodule

// File: rtl/dlx_path.sv
// One transfer direction: strobe edge detect, strobe-enable gating, storage
// and pad drive enable. The drive enable is held off during reset.
module dlx_path
    import dlx_pkg::*;
#(
    parameter int unsigned W = 18
) (
    input  logic         clk,
    input  logic         rst_n,
    input  dlx_ctrl_t    ctrl,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout,
    output logic         drive
);
    logic rise;
    logic load_en;
    logic le;
    logic ce_n;
    logic strobe;

    // Split out the control fields for readability.
    always_comb begin
        le     = ctrl.le;
        ce_n   = ctrl.ce_n;
        strobe = ctrl.strobe;
    end

    dlx_strobe_edge u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .strobe (strobe),
        .rise   (rise)
    );

    // A strobe edge loads only while the strobe enable is asserted.
    always_comb load_en = rise & ~ce_n;

    dlx_store_cell #(.W(W)) u_cell (
        .clk     (clk),
        .rst_n   (rst_n),
        .le      (le),
        .load_en (load_en),
        .din     (din),
        .dout    (dout)
    );

    // Drive the pads only when enabled and out of reset.
    always_comb drive = rst_n & ~ctrl.oe_n;

    // R4: an enabled rising strobe loads the source word, visible next cycle.
    p_strobe_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !le && !ce_n && strobe && !$past(strobe))
        |=> (le || dout == $past(din)));

    // R5: with the strobe enable off, the latched word does not move.
    p_ce_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!le && ce_n) |=> (le || $stable(dout)));

    // R6: a steady strobe never loads while latched.
    p_steady_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !le && strobe == $past(strobe)) |=> (le || $stable(dout)));

    // R7: a high output enable keeps the pads undriven.
    p_hiz_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl.oe_n |-> !drive);

    // R1: no drive at any clock edge while reset is held.
    always_ff @(posedge clk) begin
        if (!rst_n) a_reset_undriven_r1: assert (!drive);
    end
endmodule

// File: rtl/duplex_latch_xcvr.sv
// Two-way latched/registered bus transceiver.
// Direction 0 carries side A to side B, direction 1 carries side B to side A.
// Each direction has an independent dlx_path. The clash flag reports both
// sides driving at once but changes neither drive enable.
module duplex_latch_xcvr
    import dlx_pkg::*;
#(
    parameter int unsigned W = 18
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] a_in,
    output logic [W-1:0] a_out,
    output logic         a_drive,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] b_out,
    output logic         b_drive,
    input  logic         ab_oe_n,
    input  logic         ab_le,
    input  logic         ab_strobe,
    input  logic         ab_ce_n,
    input  logic         ba_oe_n,
    input  logic         ba_le,
    input  logic         ba_strobe,
    input  logic         ba_ce_n,
    output logic         bus_clash
);
    localparam int unsigned NDIR = DLX_NDIR;

    logic [W-1:0]    dir_src [NDIR];
    logic [W-1:0]    dir_dst [NDIR];
    dlx_ctrl_t       dir_ctl [NDIR];
    logic [NDIR-1:0] dir_drv;

    // Route pads and controls into the per-direction arrays.
    always_comb begin
        dir_src[0] = a_in;
        dir_src[1] = b_in;
        dir_ctl[0] = {ab_oe_n, ab_le, ab_strobe, ab_ce_n};
        dir_ctl[1] = {ba_oe_n, ba_le, ba_strobe, ba_ce_n};
    end

    for (genvar d = 0; d < NDIR; d++) begin : g_dir
        dlx_path #(.W(W)) u_path (
            .clk   (clk),
            .rst_n (rst_n),
            .ctrl  (dir_ctl[d]),
            .din   (dir_src[d]),
            .dout  (dir_dst[d]),
            .drive (dir_drv[d])
        );
    end

    // Deliver each direction's word and drive enable to the opposite side.
    always_comb begin
        b_out   = dir_dst[0];
        b_drive = dir_drv[0];
        a_out   = dir_dst[1];
        a_drive = dir_drv[1];
    end

    // Flag simultaneous drive on both sides.
    always_comb bus_clash = &dir_drv;

    // R9: both output enables asserted out of reset must raise the flag.
    p_clash_seen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!ab_oe_n && !ba_oe_n) |-> bus_clash);

    // R9: the flag never rises while one side is undriven.
    p_clash_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_clash |-> (a_drive && b_drive));
endmodule

// File: tb/duplex_latch_xcvr_tb.sv
`timescale 1ns/1ps
module duplex_latch_xcvr_tb;
    localparam int unsigned W = 6;
    localparam logic [W-1:0] MASK = '1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [W-1:0] a_in = '0, b_in = '0;
    logic [W-1:0] a_out, b_out;
    logic a_drive, b_drive, bus_clash;
    logic ab_oe_n = 1'b1, ab_le = 1'b0, ab_strobe = 1'b0, ab_ce_n = 1'b1;
    logic ba_oe_n = 1'b1, ba_le = 1'b0, ba_strobe = 1'b0, ba_ce_n = 1'b1;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    // Reference state per direction: stored word and previous strobe sample.
    logic [W-1:0] m_st [2];
    logic         m_sq [2];

    always #2 clk = ~clk;

    duplex_latch_xcvr #(.W(W)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .a_in(a_in), .a_out(a_out), .a_drive(a_drive),
        .b_in(b_in), .b_out(b_out), .b_drive(b_drive),
        .ab_oe_n(ab_oe_n), .ab_le(ab_le), .ab_strobe(ab_strobe), .ab_ce_n(ab_ce_n),
        .ba_oe_n(ba_oe_n), .ba_le(ba_le), .ba_strobe(ba_strobe), .ba_ce_n(ba_ce_n),
        .bus_clash(bus_clash)
    );

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h t=%0t", tag, what, act, exp, $time);
        end
    endtask

    // Next stored word for one direction, from the requirements.
    function automatic logic [W-1:0] next_st(input logic rst, input logic le, input logic stb,
                                             input logic ce_n, input logic sq,
                                             input logic [W-1:0] st, input logic [W-1:0] src);
        if (!rst)                   return '0;
        if (le)                     return src;
        if (stb && !sq && !ce_n)    return src;
        return st;
    endfunction

    // One cycle: inputs were set at the falling edge; check, then cross the rising edge.
    task automatic cyc(input string tag, input bit xb = 1'b0, input logic [W-1:0] eb = '0,
                       input bit xa = 1'b0, input logic [W-1:0] ea = '0);
        logic [W-1:0] exp_b, exp_a, n0, n1;
        logic d0, d1;
        #1;
        exp_b = ab_le ? a_in : m_st[0];
        exp_a = ba_le ? b_in : m_st[1];
        d0 = rst_n & ~ab_oe_n;
        d1 = rst_n & ~ba_oe_n;
        chk(tag, "b_out", 32'(b_out), 32'(exp_b));
        chk(tag, "a_out", 32'(a_out), 32'(exp_a));
        chk(tag, "b_drive", 32'(b_drive), 32'(d0));
        chk(tag, "a_drive", 32'(a_drive), 32'(d1));
        chk(tag, "bus_clash", 32'(bus_clash), 32'(d0 & d1));
        if (xb) chk(tag, "b_out fixed", 32'(b_out), 32'(eb));
        if (xa) chk(tag, "a_out fixed", 32'(a_out), 32'(ea));
        n0 = next_st(rst_n, ab_le, ab_strobe, ab_ce_n, m_sq[0], m_st[0], a_in);
        n1 = next_st(rst_n, ba_le, ba_strobe, ba_ce_n, m_sq[1], m_st[1], b_in);
        @(posedge clk);
        m_st[0] = n0;
        m_st[1] = n1;
        m_sq[0] = rst_n ? ab_strobe : 1'b1;
        m_sq[1] = rst_n ? ba_strobe : 1'b1;
        @(negedge clk);
    endtask

    initial begin
        m_st[0] = '0; m_st[1] = '0; m_sq[0] = 1'b1; m_sq[1] = 1'b1;
        @(posedge clk);
        @(negedge clk);
        // R1: reset with output enables low and strobes high: no drive, stores zero.
        ab_oe_n = 1'b0; ba_oe_n = 1'b0; ab_strobe = 1'b1; ba_strobe = 1'b1;
        ab_ce_n = 1'b0; ba_ce_n = 1'b0; a_in = 6'h15; b_in = 6'h2A;
        cyc("R1", 1'b1, '0, 1'b1, '0);
        cyc("R1", 1'b1, '0, 1'b1, '0);
        rst_n = 1'b1;
        // R1: strobe already high at release is no edge.
        cyc("R1", 1'b1, '0, 1'b1, '0);
        cyc("R1", 1'b1, '0, 1'b1, '0);
        ab_oe_n = 1'b1; ba_oe_n = 1'b1; ab_strobe = 1'b0; ba_strobe = 1'b0;
        ab_ce_n = 1'b1; ba_ce_n = 1'b1;
        cyc("R7");

        // R2: transparent pass-through, walking ones and mixed words.
        ab_le = 1'b1;
        for (int k = 0; k < W; k++) begin
            a_in = W'(1) << k;
            cyc("R2", 1'b1, W'(1) << k);
        end
        a_in = 6'h2A;
        cyc("R2", 1'b1, 6'h2A);

        // R3: latch enable falls while the source word changes.
        ab_le = 1'b0; a_in = 6'h15;
        cyc("R3", 1'b1, 6'h2A);
        a_in = 6'h33;
        cyc("R3", 1'b1, 6'h2A);

        // R4: enabled strobe edge loads; new word shows from the next cycle.
        ab_ce_n = 1'b0; ab_strobe = 1'b0;
        cyc("R4", 1'b1, 6'h2A);
        ab_strobe = 1'b1; a_in = 6'h0C;
        cyc("R4", 1'b1, 6'h2A);
        a_in = 6'h3F;
        cyc("R4", 1'b1, 6'h0C);

        // R6: strobe held high, then low, while data moves.
        a_in = 6'h01;
        cyc("R6", 1'b1, 6'h0C);
        ab_strobe = 1'b0; a_in = 6'h22;
        cyc("R6", 1'b1, 6'h0C);
        cyc("R6", 1'b1, 6'h0C);
        // R6: latch enable falls with strobe already high.
        ab_le = 1'b1; ab_strobe = 1'b1; a_in = 6'h05;
        cyc("R2", 1'b1, 6'h05);
        ab_le = 1'b0; a_in = 6'h3A;
        cyc("R6", 1'b1, 6'h05);
        cyc("R6", 1'b1, 6'h05);

        // R5: strobe enable off, edges ignored.
        ab_ce_n = 1'b1; ab_strobe = 1'b0;
        cyc("R5", 1'b1, 6'h05);
        ab_strobe = 1'b1; a_in = 6'h1B;
        cyc("R5", 1'b1, 6'h05);
        ab_strobe = 1'b0;
        cyc("R5", 1'b1, 6'h05);

        // R7: output enable toggles, stored word untouched.
        ab_oe_n = 1'b0;
        cyc("R7", 1'b1, 6'h05);
        ab_oe_n = 1'b1;
        cyc("R7", 1'b1, 6'h05);
        ab_oe_n = 1'b0;
        cyc("R7", 1'b1, 6'h05);

        // R8: B-to-A path on its own controls, A-to-B store unaffected.
        ba_le = 1'b1; b_in = 6'h11;
        cyc("R8", 1'b1, 6'h05, 1'b1, 6'h11);
        ba_le = 1'b0; b_in = 6'h2E; ba_ce_n = 1'b0; ba_strobe = 1'b0;
        cyc("R8", 1'b1, 6'h05, 1'b1, 6'h11);
        ba_strobe = 1'b1; b_in = 6'h09;
        cyc("R8", 1'b1, 6'h05, 1'b1, 6'h11);
        cyc("R8", 1'b1, 6'h05, 1'b1, 6'h09);

        // R9: both sides driving raises the clash flag.
        ba_oe_n = 1'b0;
        cyc("R9");
        ab_oe_n = 1'b1;
        cyc("R9");

        // R8: long sweep of mixed control patterns in both directions.
        for (int i = 0; i < 3000; i++) begin
            logic [15:0] h;
            h = 16'(i * 37) ^ 16'(i >> 2) ^ 16'(i * i);
            ab_le = h[0] & h[1];     ab_strobe = h[2]; ab_ce_n = h[3] & h[4]; ab_oe_n = h[5];
            ba_le = h[6] & h[7];     ba_strobe = h[8]; ba_ce_n = h[9] & h[10]; ba_oe_n = h[11];
            a_in = W'(i * 7 + 1) & MASK;
            b_in = W'(i * 11 + 5) & MASK;
            rst_n = !(i >= 1500 && i < 1502);
            cyc(rst_n ? "R8" : "R1");
        end
        rst_n = 1'b1;

        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule